// File: doc/BRIEF.md
# Register-Controlled General Purpose Output Port

This block gives software eight output bits that can each be set to one of four pin states: driven low, driven high, floating, or following an internal status signal. Three byte-wide registers on a simple register bus hold the per-bit settings. One register enables each bit. One register picks normal drive or float for each bit. One register holds the level that each bit drives. A separate per-bit status-select input switches an enabled, normally driven bit from its register level to the matching status input.

The six low bits go to one of two pad groups, chosen by a single routing bit held in a fourth register. The two high bits always go to two shared PWM pads. For every pad, the block provides three signals: data, output-enable, and a take-over flag. The pad mux uses the take-over flag to let the port replace the pad's normal function.

An external active-low reset pin is synchronized and then checked for width. Only a low level that lasts longer than a set number of clock cycles returns the registers to their power-on values. A shorter low pulse is ignored.

Top module: `gpo_port`

## Requirements
- R1: After power-on reset, the enable register reads 0x00, the type register reads 0xFF, the value register reads 0x00 and the routing register reads 0x00. No pad has its output-enable or take-over flag set.
- R2: The registers are mapped as follows: enable at 0x008, type at 0x009, value at 0x00A, and the routing bit at bit 5 of 0x13C. A write to an address takes effect at the next clock edge. A read returns the register contents on `rdata_o` in the cycle after the read strobe, and `rdata_o` holds that value until the next read.
- R3: A read from any other address returns 0x00. A write to any other address changes no register and no pad output.
- R4: An enabled bit with type 0 (normal) and status-select 0 sets output-enable on its pad and drives the value-register bit (0 = low, 1 = high).
- R5: An enabled bit with type 1 (float) clears its pad's output-enable whatever the value register holds, while its take-over flag stays set.
- R6: A disabled bit clears both the take-over flag and the output-enable of its pad and drives data 0, so the pad keeps its normal function.
- R7: An enabled, normally driven bit with status-select 1 drives `status_i` of that bit in place of the value-register bit.
- R8: With the routing bit at 1, bits 0 to 5 appear on `srgb_*[0..5]` in the same order. With the routing bit at 0, they appear on `rgb_*[0..5]` (red bits 0 and 1, then green bits 0 and 1, then blue bits 0 and 1). The same pad index is never taken over in both groups at once.
- R9: Bits 6 and 7 appear on `pwm_*[0]` and `pwm_*[1]` whatever the routing bit holds.
- R10: When `ext_rst_ni` stays low for 17 or more consecutive clock cycles, all registers return to their R1 values. A low pulse of 16 cycles or fewer changes nothing, and the width count starts again from zero each time the synchronized pin goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_ni | input | 1 | External reset pin, active low, width-qualified |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 9 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| status_sel_i | input | 8 | Per-bit selection of status mode |
| status_i | input | 8 | Per-bit internal status signals |
| srgb_do_o | output | 6 | Serial-RGB pad group data |
| srgb_oe_o | output | 6 | Serial-RGB pad group output-enable |
| srgb_sel_o | output | 6 | Serial-RGB pads taken over by the port |
| rgb_do_o | output | 6 | Colour pad group data (R0,R1,G0,G1,B0,B1) |
| rgb_oe_o | output | 6 | Colour pad group output-enable |
| rgb_sel_o | output | 6 | Colour pads taken over by the port |
| pwm_do_o | output | 2 | PWM pad data |
| pwm_oe_o | output | 2 | PWM pad output-enable |
| pwm_sel_o | output | 2 | PWM pads taken over by the port |

## Verification
Every bit is put, under both routing settings, through six configurations: driven low, driven high, floating with value 1, status mode with status 1 and value 0, status mode with status 0 and value 1, and disabled with value 1. The two status cases tell the status path apart from the value path. The floating and disabled cases tell a cleared output-enable from a released pad. In each configuration, all 42 pad signals are compared, so a bit that leaks onto the wrong group or index is also caught. Reset pulses of 16 and 17 cycles, and two 10-cycle pulses with a one-cycle gap, tell the width limit and the counter restart apart from a plain level reset.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int ADDR_W    = 9;
  localparam int ROUTE_BIT = 5;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 9'h008;
  localparam logic [ADDR_W-1:0] ADDR_TYPE  = 9'h009;
  localparam logic [ADDR_W-1:0] ADDR_VAL   = 9'h00A;
  localparam logic [ADDR_W-1:0] ADDR_ROUTE = 9'h13C;
endpackage

// File: rtl/gpo_rst_qual.sv
module gpo_rst_qual #(
  parameter int MIN_LOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  output logic qual_rst_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW);

  logic meta_q, sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= ext_rst_ni;
      sync_q <= meta_q;
    end
  end

  // counts cycles already spent low; saturates at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (sync_q)        cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  assign qual_rst_o = !sync_q && (cnt_q == LIM);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM); // R10
  AST_HIGH_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |=> cnt_q == '0); // R10
  AST_QUAL_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_rst_o |-> !$past(sync_q)); // R10
endmodule

// File: rtl/gpo_regs.sv
module gpo_regs
  import gpo_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      typ_o,
  output logic [N-1:0]      val_o,
  output logic              route_o,
  output logic [N-1:0]      rdata_o
);
  logic hit_en, hit_typ, hit_val, hit_route, mapped;
  logic [N-1:0] rd_mux;

  assign hit_en    = addr_i == ADDR_EN;
  assign hit_typ   = addr_i == ADDR_TYPE;
  assign hit_val   = addr_i == ADDR_VAL;
  assign hit_route = addr_i == ADDR_ROUTE;
  assign mapped    = hit_en | hit_typ | hit_val | hit_route;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      typ_o   <= '1;
      val_o   <= '0;
      route_o <= 1'b0;
    end else if (clr_i) begin
      en_o    <= '0;
      typ_o   <= '1;
      val_o   <= '0;
      route_o <= 1'b0;
    end else if (wr_en_i) begin
      if (hit_en)    en_o    <= wdata_i;
      if (hit_typ)   typ_o   <= wdata_i;
      if (hit_val)   val_o   <= wdata_i;
      if (hit_route) route_o <= wdata_i[ROUTE_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_en)    rd_mux = en_o;
    if (hit_typ)   rd_mux = typ_o;
    if (hit_val)   rd_mux = val_o;
    if (hit_route) rd_mux[ROUTE_BIT] = route_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  AST_CLR_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (en_o == '0 && typ_o == '1 && val_o == '0 && !route_o)); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !mapped) |=> rdata_o == '0); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/gpo_route.sv
module gpo_route #(
  parameter int N     = 8,
  parameter int LOW_W = 6
) (
  input  logic [N-1:0]       en_i,
  input  logic [N-1:0]       typ_i,
  input  logic [N-1:0]       val_i,
  input  logic               route_i,
  input  logic [N-1:0]       status_sel_i,
  input  logic [N-1:0]       status_i,
  output logic [LOW_W-1:0]   srgb_do_o,
  output logic [LOW_W-1:0]   srgb_oe_o,
  output logic [LOW_W-1:0]   srgb_sel_o,
  output logic [LOW_W-1:0]   rgb_do_o,
  output logic [LOW_W-1:0]   rgb_oe_o,
  output logic [LOW_W-1:0]   rgb_sel_o,
  output logic [N-LOW_W-1:0] pwm_do_o,
  output logic [N-LOW_W-1:0] pwm_oe_o,
  output logic [N-LOW_W-1:0] pwm_sel_o
);
  logic [N-1:0] drive;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign drive[i] = status_sel_i[i] ? status_i[i] : val_i[i];
    if (i < LOW_W) begin : g_low
      assign srgb_sel_o[i] = en_i[i] & route_i;
      assign rgb_sel_o[i]  = en_i[i] & ~route_i;
      assign srgb_oe_o[i]  = srgb_sel_o[i] & ~typ_i[i];
      assign rgb_oe_o[i]   = rgb_sel_o[i] & ~typ_i[i];
      assign srgb_do_o[i]  = srgb_sel_o[i] & drive[i];
      assign rgb_do_o[i]   = rgb_sel_o[i] & drive[i];
    end else begin : g_pwm
      assign pwm_sel_o[i-LOW_W] = en_i[i];
      assign pwm_oe_o[i-LOW_W]  = en_i[i] & ~typ_i[i];
      assign pwm_do_o[i-LOW_W]  = en_i[i] & drive[i];
    end
  end
endmodule

// File: rtl/gpo_port.sv
module gpo_port
  import gpo_pkg::*;
#(
  parameter int N       = 8,
  parameter int LOW_W   = 6,
  parameter int MIN_LOW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      status_sel_i,
  input  logic [N-1:0]      status_i,
  output logic [LOW_W-1:0]  srgb_do_o,
  output logic [LOW_W-1:0]  srgb_oe_o,
  output logic [LOW_W-1:0]  srgb_sel_o,
  output logic [LOW_W-1:0]  rgb_do_o,
  output logic [LOW_W-1:0]  rgb_oe_o,
  output logic [LOW_W-1:0]  rgb_sel_o,
  output logic [N-LOW_W-1:0] pwm_do_o,
  output logic [N-LOW_W-1:0] pwm_oe_o,
  output logic [N-LOW_W-1:0] pwm_sel_o
);
  logic         qual_rst;
  logic [N-1:0] en, typ, val;
  logic         route;

  gpo_rst_qual #(.MIN_LOW(MIN_LOW)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_rst_ni (ext_rst_ni),
    .qual_rst_o (qual_rst)
  );

  gpo_regs #(.N(N)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (qual_rst),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .en_o    (en),
    .typ_o   (typ),
    .val_o   (val),
    .route_o (route),
    .rdata_o (rdata_o)
  );

  gpo_route #(.N(N), .LOW_W(LOW_W)) u_route (
    .en_i         (en),
    .typ_i        (typ),
    .val_i        (val),
    .route_i      (route),
    .status_sel_i (status_sel_i),
    .status_i     (status_i),
    .srgb_do_o    (srgb_do_o),
    .srgb_oe_o    (srgb_oe_o),
    .srgb_sel_o   (srgb_sel_o),
    .rgb_do_o     (rgb_do_o),
    .rgb_oe_o     (rgb_oe_o),
    .rgb_sel_o    (rgb_sel_o),
    .pwm_do_o     (pwm_do_o),
    .pwm_oe_o     (pwm_oe_o),
    .pwm_sel_o    (pwm_sel_o)
  );

  AST_GROUP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srgb_sel_o & rgb_sel_o) == '0); // R8
  AST_FLOAT_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((srgb_oe_o | rgb_oe_o) & typ[LOW_W-1:0]) == '0 && (pwm_oe_o & typ[N-1:LOW_W]) == '0); // R5
  AST_OE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((srgb_oe_o | rgb_oe_o) & ~en[LOW_W-1:0]) == '0 && (pwm_oe_o & ~en[N-1:LOW_W]) == '0); // R6
endmodule

// File: tb/gpo_port_test.sv
`timescale 1ns/1ps
module gpo_port_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_rst_ni = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] ssel = '0, stat = '0;
  logic [5:0] srgb_do, srgb_oe, srgb_sel, rgb_do, rgb_oe, rgb_sel;
  logic [1:0] pwm_do, pwm_oe, pwm_sel;

  int checks = 0, errors = 0;
  logic [7:0] m_en = 8'h00, m_typ = 8'hFF, m_val = 8'h00;
  logic m_route = 1'b0;

  always #2.5 clk = ~clk;

  gpo_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .status_sel_i(ssel), .status_i(stat),
    .srgb_do_o(srgb_do), .srgb_oe_o(srgb_oe), .srgb_sel_o(srgb_sel),
    .rgb_do_o(rgb_do), .rgb_oe_o(rgb_oe), .rgb_sel_o(rgb_sel),
    .pwm_do_o(pwm_do), .pwm_oe_o(pwm_oe), .pwm_sel_o(pwm_sel)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    if (a == 9'h008) m_en = d;
    if (a == 9'h009) m_typ = d;
    if (a == 9'h00A) m_val = d;
    if (a == 9'h13C) m_route = d[5];
  endtask

  task automatic rd(logic [8:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic check_pads(string req);
    logic [5:0] esd, eso, esl, erd, ero, erl;
    logic [1:0] epd, epo, epl;
    esd = '0; eso = '0; esl = '0; erd = '0; ero = '0; erl = '0;
    epd = '0; epo = '0; epl = '0;
    for (int i = 0; i < 8; i++) begin
      logic d;
      d = ssel[i] ? stat[i] : m_val[i];
      if (m_en[i]) begin
        if (i >= 6) begin
          epl[i-6] = 1'b1; epo[i-6] = ~m_typ[i]; epd[i-6] = d;
        end else if (m_route) begin
          esl[i] = 1'b1; eso[i] = ~m_typ[i]; esd[i] = d;
        end else begin
          erl[i] = 1'b1; ero[i] = ~m_typ[i]; erd[i] = d;
        end
      end
    end
    chk(req, {22'd0, srgb_do, srgb_oe, srgb_sel, rgb_do, rgb_oe, rgb_sel, pwm_do, pwm_oe, pwm_sel},
             {22'd0, esd, eso, esl, erd, ero, erl, epd, epo, epl});
  endtask

  task automatic ext_pulse(int n);
    @(negedge clk); ext_rst_ni = 1'b0;
    repeat (n) @(negedge clk);
    ext_rst_ni = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset_defaults();
    logic [7:0] d;
    check_pads("R1 pads after reset");
    chk("R1 no oe", {58'd0, srgb_oe | rgb_oe}, 64'd0);
    rd(9'h008, d); chk("R1 enable default", d, 8'h00);
    rd(9'h009, d); chk("R1 type default", d, 8'hFF);
    rd(9'h00A, d); chk("R1 value default", d, 8'h00);
    rd(9'h13C, d); chk("R1 route default", d, 8'h00);
  endtask

  task automatic t_reg_rw();
    logic [7:0] d;
    wr(9'h008, 8'h3C); wr(9'h009, 8'hA5); wr(9'h00A, 8'h96); wr(9'h13C, 8'hFF);
    rd(9'h008, d); chk("R2 enable rw", d, 8'h3C);
    rd(9'h009, d); chk("R2 type rw", d, 8'hA5);
    rd(9'h00A, d); chk("R2 value rw", d, 8'h96);
    rd(9'h13C, d); chk("R2 route rw bit5", d, 8'h20);
    check_pads("R2 pads follow registers");
    repeat (3) @(negedge clk);
    chk("R2 rdata held", rdata, 8'h20);
    wr(9'h13C, 8'hDF);
    rd(9'h13C, d); chk("R2 route clear", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(9'h008, 8'hFF); wr(9'h009, 8'h00); wr(9'h00A, 8'h55);
    rd(9'h00B, d); chk("R3 unmapped read 0x00B", d, 8'h00);
    rd(9'h13D, d); chk("R3 unmapped read 0x13D", d, 8'h00);
    @(negedge clk); wr_en = 1'b1; addr = 9'h10A; wdata = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); wr_en = 1'b1; addr = 9'h007; wdata = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    check_pads("R3 unmapped write no effect");
    rd(9'h00A, d); chk("R3 value untouched", d, 8'h55);
    rd(9'h008, d); chk("R3 enable untouched", d, 8'hFF);
  endtask

  // states: 0 low, 1 high, 2 float, 3 status=1/val=0, 4 status=0/val=1, 5 disabled
  task automatic t_pin_states();
    string tags [6] = '{"R4 drive low", "R4 drive high", "R5 float",
                        "R7 status one", "R7 status zero", "R6 disabled"};
    for (int r = 0; r < 2; r++) begin
      wr(9'h13C, r[0] ? 8'h20 : 8'h00);
      for (int b = 0; b < 8; b++) begin
        for (int s = 0; s < 6; s++) begin
          logic [7:0] m;
          m = 8'h01 << b;
          ssel = (s == 3 || s == 4) ? m : 8'h00;
          stat = (s == 3) ? m : 8'h00;
          wr(9'h008, (s == 5) ? 8'h00 : m);
          wr(9'h009, (s == 2) ? m : 8'h00);
          wr(9'h00A, (s == 1 || s == 2 || s == 4 || s == 5) ? m : 8'h00);
          check_pads($sformatf("%s bit%0d %s", tags[s], b,
                     b >= 6 ? "R9 pwm" : (r[0] ? "R8 srgb" : "R8 rgb")));
        end
      end
    end
    ssel = '0; stat = '0;
  endtask

  task automatic t_ext_reset();
    logic [7:0] d;
    wr(9'h008, 8'hF0); wr(9'h009, 8'h0F); wr(9'h00A, 8'hAA); wr(9'h13C, 8'h20);
    ext_pulse(16);
    rd(9'h008, d); chk("R10 16-cycle pulse ignored en", d, 8'hF0);
    rd(9'h009, d); chk("R10 16-cycle pulse ignored type", d, 8'h0F);
    ext_pulse(10); ext_pulse(10);
    rd(9'h00A, d); chk("R10 split pulses ignored", d, 8'hAA);
    @(negedge clk); ext_rst_ni = 1'b0;
    repeat (10) @(negedge clk); ext_rst_ni = 1'b1;
    @(negedge clk); ext_rst_ni = 1'b0;
    repeat (10) @(negedge clk); ext_rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    rd(9'h13C, d); chk("R10 one-cycle gap restarts count", d, 8'h20);
    ext_pulse(17);
    m_en = 8'h00; m_typ = 8'hFF; m_val = 8'h00; m_route = 1'b0;
    rd(9'h008, d); chk("R10 17-cycle reset en", d, 8'h00);
    rd(9'h009, d); chk("R10 17-cycle reset type", d, 8'hFF);
    rd(9'h00A, d); chk("R10 17-cycle reset value", d, 8'h00);
    rd(9'h13C, d); chk("R10 17-cycle reset route", d, 8'h00);
    check_pads("R10 pads float after reset");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_defaults();
    t_reg_rw();
    t_unmapped();
    t_pin_states();
    t_ext_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule